// File: doc/BRIEF.md
# Display Controller Configuration Header with Aliased Frame-Buffer Base

This block holds the byte-addressed configuration header of a display controller that sits on a PCI-style bus. The bus front end hands it one configuration access per cycle. Each access is an 8-bit offset, a write strobe and a write byte. The block returns the read byte in the same cycle. Writes take effect at the next clock edge, and each offset has its own write mask. The chip variant is fixed at elaboration time, and it decides which fields exist, how wide they are and what they read back.

The frame-buffer base address register has no storage of its own. Its upper two bytes are views of two extended display registers, here called the base-high and base-low registers. The display host can also write these two registers through a second write port. The block drives the I/O-decode enable, the memory-decode enable and the 16-bit frame-buffer base to the address decoders. It also drives a one-cycle pulse that tells the decoders to reload their mapping.

The variant parameter takes three values. 0 is the legacy part, 1 is the mid part and 2 is the newest part. Parameters 1 and 2 together are called the newer variants.

Top module: `cfg_hdr`

## Requirements
- R1: A write to offset 0x04 stores the command byte masked with 0x23 on the legacy variant and with 0x27 on the newer variants. A read at 0x04 returns the stored byte.
- R2: `io_en` follows command bit 0 and `mem_en` follows command bit 1. `map_update` is high for the cycle after any write to 0x04 or 0x13, and after a write to 0x12 on the legacy variant only.
- R3: On the newest variant, offset 0x07 reads the status byte masked with 0x36, and it reads 0x02 after reset. `abort_evt[0]` sets bit 4 and `abort_evt[1]` sets bit 5. Writing 1 to bit 4 or bit 5 clears that bit, and a set in the same cycle wins over the clear. Writing any other bit has no effect.
- R4: On the legacy and mid variants, offset 0x07 always reads 0x02, and neither writes nor abort events change it.
- R5: Offset 0x08 reads 0x00 on the legacy variant, 0x40 on the mid variant and 0x16 on the newest variant.
- R6: On the newest variant, offset 0x0D stores and returns the written byte masked with 0xF8. On the other variants it reads 0x00.
- R7: Offsets 0x10 and 0x11 read 0x00 whatever is written. Any offset not named in R1 to R10 also reads 0x00.
- R8: On the legacy variant, offset 0x12 reads bit 7 of base-low (mask 0x80). A write there stores `wdata & 0x80` into base-low and clears its lower seven bits. On the newer variants, 0x12 reads 0x00 and a write leaves base-low unchanged.
- R9: Offset 0x13 aliases base-high. On the newer variants a config write stores the byte masked with 0xFC and a read returns base-high masked with 0xFC. On the legacy variant all 8 bits pass through in both directions.
- R10: With the ROM present, offset 0x30 reads bit 0 of the last byte written there. Without the ROM it reads 0x00.
- R11: A host write (`host_sel` 0 selects base-high, 1 selects base-low) stores the full byte at the next edge. If a config write hits the same register in the same cycle, the config write wins.
- R12: `fb_base` is {base-high read view, base-low & 0x80} on the legacy variant and {base-high & 0xFC, 8'h00} on the newer variants.
- R13: After reset, the command byte, base-high, base-low, the latency byte and the ROM bit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte, same cycle |
| abort_evt | input | 2 | Error events; bit 0 sets status bit 4, bit 1 sets status bit 5 |
| host_we | input | 1 | Host extended-register write strobe |
| host_sel | input | 1 | 0 selects base-high, 1 selects base-low |
| host_wdata | input | 8 | Host write byte |
| xr_base_hi_q | output | 8 | Current base-high register |
| xr_base_lo_q | output | 8 | Current base-low register |
| io_en | output | 1 | I/O decode enable |
| mem_en | output | 1 | Memory decode enable |
| fb_base | output | 16 | Frame-buffer base, address bits 31:16 |
| map_update | output | 1 | One-cycle pulse to reload the address mapping |

## Verification
The assertions assume that every input is a known value from the first clock edge. They also assume that `abort_evt` reflects real error events at any time, even in the same cycle as a status write. The stimulus drives all inputs to defined values from time zero and changes them only between clock edges. It places one abort pulse in its own cycle and then clears the status bits with separate writes. The collision case is exercised on purpose: one cycle carries both a config write and a host write to the same register, so the priority rule is checked.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int VAR_LEGACY = 0;
  localparam int VAR_MID    = 1;
  localparam int VAR_NEWEST = 2;

  localparam logic [7:0] OFS_CMD    = 8'h04;
  localparam logic [7:0] OFS_STATHI = 8'h07;
  localparam logic [7:0] OFS_REV    = 8'h08;
  localparam logic [7:0] OFS_LAT    = 8'h0D;
  localparam logic [7:0] OFS_BAR2   = 8'h12;
  localparam logic [7:0] OFS_BAR3   = 8'h13;
  localparam logic [7:0] OFS_ROM    = 8'h30;

  function automatic logic is_newer(int v);
    return v != VAR_LEGACY;
  endfunction

  function automatic logic [7:0] cmd_wmask(int v);
    return is_newer(v) ? 8'h27 : 8'h23;
  endfunction

  function automatic logic [7:0] base_hi_mask(int v);
    return is_newer(v) ? 8'hFC : 8'hFF;
  endfunction

  function automatic logic [7:0] rev_id(int v);
    case (v)
      VAR_MID:    return 8'h40;
      VAR_NEWEST: return 8'h16;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] stat_next(logic [7:0] cur, logic clr_we,
                                           logic [7:0] wdata, logic [1:0] evt);
    logic [7:0] clr;
    clr = clr_we ? (wdata & 8'h30) : 8'h00;
    return (cur & ~clr) | {2'b00, evt, 4'h0};
  endfunction
endpackage

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
  import cfg_hdr_pkg::*;
#(
  parameter int VARIANT = VAR_NEWEST,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    abort_evt,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] lat_q,
  output logic          rom_q
);
  logic wr_cmd, wr_stat, wr_lat, wr_rom;
  assign wr_cmd  = wr_en && addr == OFS_CMD;
  assign wr_stat = wr_en && addr == OFS_STATHI;
  assign wr_lat  = wr_en && addr == OFS_LAT;
  assign wr_rom  = wr_en && addr == OFS_ROM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= 8'h02;
      lat_q  <= '0;
      rom_q  <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= wdata & cmd_wmask(VARIANT);
      stat_q <= stat_next(stat_q, wr_stat, wdata, abort_evt);
      if (wr_lat) lat_q <= wdata & 8'hF8;
      if (wr_rom) rom_q <= wdata[0];
    end
  end
endmodule

// File: rtl/ext_alias_regs.sv
module ext_alias_regs
  import cfg_hdr_pkg::*;
#(
  parameter int VARIANT = VAR_NEWEST,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] hi_q,
  output logic [DW-1:0] lo_q
);
  logic cfg_hi_wr, cfg_lo_wr;
  assign cfg_hi_wr = cfg_we && cfg_addr == OFS_BAR3;

  generate
    if (VARIANT == VAR_LEGACY) begin : g_lo_alias
      assign cfg_lo_wr = cfg_we && cfg_addr == OFS_BAR2;
    end else begin : g_lo_plain
      assign cfg_lo_wr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (cfg_hi_wr)                  hi_q <= cfg_wdata & base_hi_mask(VARIANT);
      else if (host_we && !host_sel)  hi_q <= host_wdata;
      if (cfg_lo_wr)                  lo_q <= cfg_wdata & 8'h80;
      else if (host_we && host_sel)   lo_q <= host_wdata;
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_hdr_pkg::*;
#(
  parameter int VARIANT = VAR_NEWEST,
  parameter bit HAS_ROM = 1'b1,
  parameter int DW      = 8
) (
  input  logic [7:0]    addr,
  input  logic [DW-1:0] cmd_q,
  input  logic [DW-1:0] stat_q,
  input  logic [DW-1:0] lat_q,
  input  logic          rom_q,
  input  logic [DW-1:0] hi_q,
  input  logic [DW-1:0] lo_q,
  output logic [DW-1:0] rdata
);
  localparam bit NEWEST = (VARIANT == VAR_NEWEST);
  localparam bit LEGACY = (VARIANT == VAR_LEGACY);

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CMD:    rdata = cmd_q;
      OFS_STATHI: rdata = NEWEST ? (stat_q & 8'h36) : 8'h02;
      OFS_REV:    rdata = rev_id(VARIANT);
      OFS_LAT:    rdata = NEWEST ? lat_q : 8'h00;
      OFS_BAR2:   rdata = LEGACY ? (lo_q & 8'h80) : 8'h00;
      OFS_BAR3:   rdata = hi_q & base_hi_mask(VARIANT);
      OFS_ROM:    rdata = HAS_ROM ? {7'b0, rom_q} : 8'h00;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_hdr.sv
module cfg_hdr
  import cfg_hdr_pkg::*;
#(
  parameter int VARIANT = VAR_NEWEST,
  parameter bit HAS_ROM = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic [1:0]  abort_evt,
  input  logic        host_we,
  input  logic        host_sel,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  xr_base_hi_q,
  output logic [7:0]  xr_base_lo_q,
  output logic        io_en,
  output logic        mem_en,
  output logic [15:0] fb_base,
  output logic        map_update
);
  localparam int  DW     = 8;
  localparam bit  LEGACY = (VARIANT == VAR_LEGACY);

  logic [DW-1:0] cmd_q, stat_q, lat_q;
  logic          rom_q;
  logic          map_touch;

  cfg_ctrl_regs #(.VARIANT(VARIANT), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .abort_evt(abort_evt),
    .cmd_q(cmd_q), .stat_q(stat_q), .lat_q(lat_q), .rom_q(rom_q)
  );

  ext_alias_regs #(.VARIANT(VARIANT), .DW(DW)) u_ext (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .hi_q(xr_base_hi_q), .lo_q(xr_base_lo_q)
  );

  cfg_read_mux #(.VARIANT(VARIANT), .HAS_ROM(HAS_ROM), .DW(DW)) u_rmux (
    .addr(cfg_addr), .cmd_q(cmd_q), .stat_q(stat_q), .lat_q(lat_q),
    .rom_q(rom_q), .hi_q(xr_base_hi_q), .lo_q(xr_base_lo_q), .rdata(cfg_rdata)
  );

  assign map_touch = cfg_we && (cfg_addr == OFS_CMD || cfg_addr == OFS_BAR3 ||
                                (LEGACY && cfg_addr == OFS_BAR2));

  always_ff @(posedge clk) begin
    if (!rst_n) map_update <= 1'b0;
    else        map_update <= map_touch;
  end

  assign io_en   = cmd_q[0];
  assign mem_en  = cmd_q[1];
  assign fb_base = {xr_base_hi_q & base_hi_mask(VARIANT),
                    LEGACY ? (xr_base_lo_q & 8'h80) : 8'h00};
endmodule

module cfg_hdr_chk
  import cfg_hdr_pkg::*;
#(
  parameter int VARIANT = VAR_NEWEST
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic [1:0] abort_evt,
  input logic       host_we,
  input logic       host_sel,
  input logic [7:0] host_wdata,
  input logic [7:0] xr_base_hi_q,
  input logic       io_en,
  input logic       map_update,
  input logic [7:0] cmd_q,
  input logic [7:0] stat_q
);
  // R1
  cmd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_CMD) |=> cmd_q == ($past(cfg_wdata) & cmd_wmask(VARIANT)));
  // R2
  io_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_CMD) |=> io_en == $past(cfg_wdata[0]));
  // R2
  map_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == OFS_CMD || cfg_addr == OFS_BAR3)) |=> map_update);
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT == VAR_NEWEST && cfg_we && cfg_addr == OFS_STATHI && cfg_wdata[4] && !abort_evt[0])
    |=> !stat_q[4]);
  // R3
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT == VAR_NEWEST && stat_q[5] && !(cfg_we && cfg_addr == OFS_STATHI && cfg_wdata[5]))
    |=> stat_q[5]);
  // R9
  base_hi_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_BAR3) |=> xr_base_hi_q == ($past(cfg_wdata) & base_hi_mask(VARIANT)));
  // R11
  host_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_sel && !(cfg_we && cfg_addr == OFS_BAR3)) |=> xr_base_hi_q == $past(host_wdata));

  always_comb begin
    if (rst_n) begin
      // R5
      rev_read_chk: assert (cfg_addr != OFS_REV || cfg_rdata == rev_id(VARIANT));
      // R7
      bar_low_chk: assert (!(cfg_addr == 8'h10 || cfg_addr == 8'h11) || cfg_rdata == 8'h00);
    end
  end
endmodule

bind cfg_hdr cfg_hdr_chk #(.VARIANT(VARIANT)) u_chk (.*);

// File: tb/cfg_hdr_tb.sv
module cfg_hdr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic [1:0] abort_evt = '0;
  logic host_we = 1'b0, host_sel = 1'b0;
  logic [7:0] host_wdata = '0;

  logic [7:0]  rd_n, rd_m, rd_l, hi_n, hi_m, hi_l, lo_n, lo_m, lo_l;
  logic        io_n, io_m, io_l, me_n, me_m, me_l, mu_n, mu_m, mu_l;
  logic [15:0] fb_n, fb_m, fb_l;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  cfg_hdr #(.VARIANT(2), .HAS_ROM(1'b1)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata(rd_n), .abort_evt,
    .host_we, .host_sel, .host_wdata, .xr_base_hi_q(hi_n), .xr_base_lo_q(lo_n),
    .io_en(io_n), .mem_en(me_n), .fb_base(fb_n), .map_update(mu_n));
  cfg_hdr #(.VARIANT(1), .HAS_ROM(1'b1)) u_dut_mid (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata(rd_m), .abort_evt,
    .host_we, .host_sel, .host_wdata, .xr_base_hi_q(hi_m), .xr_base_lo_q(lo_m),
    .io_en(io_m), .mem_en(me_m), .fb_base(fb_m), .map_update(mu_m));
  cfg_hdr #(.VARIANT(0), .HAS_ROM(1'b0)) u_dut_leg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata(rd_l), .abort_evt,
    .host_we, .host_sel, .host_wdata, .xr_base_hi_q(hi_l), .xr_base_lo_q(lo_l),
    .io_en(io_l), .mem_en(me_l), .fb_base(fb_l), .map_update(mu_l));

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, one edge of write, return at next negedge
  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read3(logic [7:0] a, logic [7:0] en, logic [7:0] em,
                       logic [7:0] el, string tag);
    cfg_addr = a; #1;
    check({tag, " newest"}, {8'h0, rd_n}, {8'h0, en});
    check({tag, " mid"},    {8'h0, rd_m}, {8'h0, em});
    check({tag, " legacy"}, {8'h0, rd_l}, {8'h0, el});
  endtask

  task automatic t_reset;
    read3(8'h04, 8'h00, 8'h00, 8'h00, "R13 cmd reset");
    read3(8'h07, 8'h02, 8'h02, 8'h02, "R3 R4 status reset");
    read3(8'h13, 8'h00, 8'h00, 8'h00, "R13 base-high reset");
    read3(8'h0D, 8'h00, 8'h00, 8'h00, "R13 latency reset");
    check("R13 fb_base reset", fb_n | fb_m | fb_l, 16'h0);
    check("R2 io_en reset", {15'h0, io_n | io_m | io_l}, 16'h0);
  endtask

  task automatic t_cmd;
    cfg_write(8'h04, 8'hFF);
    check("R2 map_update newest", {15'h0, mu_n}, 16'h1);
    check("R2 map_update legacy", {15'h0, mu_l}, 16'h1);
    read3(8'h04, 8'h27, 8'h27, 8'h23, "R1 cmd mask");
    check("R2 io/mem newest", {14'h0, me_n, io_n}, 16'h3);
    check("R2 io/mem legacy", {14'h0, me_l, io_l}, 16'h3);
    @(negedge clk);
    check("R2 map_update falls", {15'h0, mu_n}, 16'h0);
    cfg_write(8'h04, 8'h02);
    check("R2 io off", {15'h0, io_n | io_m | io_l}, 16'h0);
    check("R2 mem on", {13'h0, me_n, me_m, me_l}, 16'h7);
  endtask

  task automatic t_status;
    abort_evt = 2'b11; @(posedge clk); @(negedge clk); abort_evt = 2'b00;
    read3(8'h07, 8'h32, 8'h02, 8'h02, "R3 R4 abort set");
    cfg_write(8'h07, 8'h10);
    read3(8'h07, 8'h22, 8'h02, 8'h02, "R3 clear bit4");
    cfg_write(8'h07, 8'hCF);
    read3(8'h07, 8'h22, 8'h02, 8'h02, "R3 other bits no effect");
    cfg_write(8'h07, 8'hFF);
    read3(8'h07, 8'h02, 8'h02, 8'h02, "R3 R4 clear all");
    cfg_addr = 8'h07; cfg_wdata = 8'h10; cfg_we = 1'b1; abort_evt = 2'b01;
    @(posedge clk); @(negedge clk); cfg_we = 1'b0; abort_evt = 2'b00;
    read3(8'h07, 8'h12, 8'h02, 8'h02, "R3 set wins");
    cfg_write(8'h07, 8'h30);
  endtask

  task automatic t_ids;
    read3(8'h08, 8'h16, 8'h40, 8'h00, "R5 revision");
    cfg_write(8'h0D, 8'hFF);
    read3(8'h0D, 8'hF8, 8'h00, 8'h00, "R6 latency");
    cfg_write(8'h10, 8'hFF);
    cfg_write(8'h11, 8'hFF);
    read3(8'h10, 8'h00, 8'h00, 8'h00, "R7 bar byte0");
    read3(8'h11, 8'h00, 8'h00, 8'h00, "R7 bar byte1");
    read3(8'h3C, 8'h00, 8'h00, 8'h00, "R7 unmapped");
    cfg_write(8'h30, 8'hFF);
    read3(8'h30, 8'h01, 8'h01, 8'h00, "R10 rom");
    cfg_write(8'h30, 8'hFE);
    read3(8'h30, 8'h00, 8'h00, 8'h00, "R10 rom clear");
  endtask

  task automatic t_bar;
    host_we = 1'b1; host_sel = 1'b1; host_wdata = 8'h7F;
    @(posedge clk); @(negedge clk); host_we = 1'b0;
    check("R11 host lo legacy", {8'h0, lo_l}, 16'h007F);
    read3(8'h12, 8'h00, 8'h00, 8'h00, "R8 bit7 view");
    cfg_write(8'h12, 8'hFF);
    check("R8 lo legacy", {8'h0, lo_l}, 16'h0080);
    check("R8 lo newest untouched", {8'h0, lo_n}, 16'h007F);
    check("R2 map_update 0x12", {14'h0, mu_n, mu_l}, 16'h1);
    read3(8'h12, 8'h00, 8'h00, 8'h80, "R8 alias read");
    cfg_write(8'h13, 8'hFF);
    read3(8'h13, 8'hFC, 8'hFC, 8'hFF, "R9 alias read");
    check("R12 fb newest", fb_n, 16'hFC00);
    check("R12 fb legacy", fb_l, 16'hFF80);
    cfg_addr = 8'h13; cfg_wdata = 8'hAA; cfg_we = 1'b1;
    host_we = 1'b1; host_sel = 1'b0; host_wdata = 8'h55;
    @(posedge clk); @(negedge clk); cfg_we = 1'b0; host_we = 1'b0;
    check("R11 prio newest", {8'h0, hi_n}, 16'h00A8);
    check("R11 prio legacy", {8'h0, hi_l}, 16'h00AA);
    host_we = 1'b1; host_wdata = 8'h33;
    @(posedge clk); @(negedge clk); host_we = 1'b0;
    check("R11 host hi", {8'h0, hi_m}, 16'h0033);
    read3(8'h13, 8'h30, 8'h30, 8'h33, "R9 host view");
    check("R12 fb mid", fb_m, 16'h3000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd();
        t_status();
        t_ids();
        t_bar();
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule